// File: doc/BRIEF.md
# Eight-Bit Instruction Decoder

This block turns one instruction byte into the complete set of control strobes for a small accumulator machine that fetches one instruction per clock. The byte carries three fields. An operation field picks one of eight operations, a mode field picks one of eight addressing and destination combinations, and a source field picks one of four bus drivers. Every one of the 256 byte values decodes to a defined instruction. For jumps, the mode field is read as a branch condition instead.

The decoder is purely combinational. The surrounding core feeds it the instruction register and the current accumulator value. It returns the ALU function, the bus driver, the RAM address form, the write enables for the accumulator, the X and Y registers and the output latch, the X post-increment, the RAM write strobe, and the two program-counter load strobes. Registers, the ALU and the memories sit outside this block.

Top module: `instrDecoder`

## Requirements
- R1: Field layout is op = instr[7:5], mode = instr[4:2], source = instr[1:0]. For every op except store, busSel equals the source field (0 immediate, 1 RAM, 2 accumulator, 3 input port).
- R2: Op 6 (store) asserts ramWe, deasserts weAc, weX, weY and weOut, and maps source 1 to busSel 0. The other sources pass through unchanged.
- R3: Op codes are 0 load, 1 AND, 2 OR, 3 XOR, 4 add, 5 subtract. aluOp equals the op field for ops 0 to 5 and is 0 (pass bus) for store and jump.
- R4: For non-jump ops, addrSel (0 [D], 1 [X], 2 [Y:D], 3 [Y:X]) is 0 for modes 0, 4, 5 and 6, 1 for mode 1, 2 for mode 2, and 3 for modes 3 and 7. Jumps use addrSel 0.
- R5: For ops 0 to 5, exactly one write enable is set: weAc for modes 0 to 3, weX for mode 4, weY for mode 5, and weOut for modes 6 and 7.
- R6: xInc is set exactly when mode is 7 and op is not jump, including store.
- R7: Op 7 with mode 0 is a far jump. It sets pcLoadFar and clears pcLoadLow, whatever the accumulator holds.
- R8: Op 7 with modes 1 to 6 sets pcLoadLow when the accumulator, read as a signed value, is greater than zero (1), less than zero (2), not zero (3), zero (4), at least zero (5), or at most zero (6).
- R9: Op 7 with mode 7 always sets pcLoadLow and never pcLoadFar.
- R10: Non-jump ops assert neither PC load. Jumps assert no register write enable, no xInc and no ramWe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 8 | Instruction register byte |
| acc | input | DATA_W | Current accumulator value |
| aluOp | output | 3 | ALU function select |
| busSel | output | 2 | Bus driver select |
| addrSel | output | 2 | RAM address form select |
| weAc | output | 1 | Accumulator write enable |
| weX | output | 1 | X register write enable |
| weY | output | 1 | Y register write enable |
| weOut | output | 1 | Output latch write enable |
| xInc | output | 1 | X post-increment enable |
| ramWe | output | 1 | RAM write enable |
| pcLoadLow | output | 1 | Load PC low byte from bus |
| pcLoadFar | output | 1 | Load PC high byte from Y and low byte from bus |

## Verification
Mode 7 is where functions overlap.

- An arithmetic op in mode 7 raises weOut and xInc together.
- A store in mode 7 raises ramWe and xInc together, while all register writes stay suppressed.

The bench sweeps all 256 bytes against several accumulator values, so every mode-7 combination is hit with each source. Each strobe is compared on its own against a model built from the requirements, so a missing increment shows up separately from a missing write.

// File: rtl/instrDecPkg.sv
package instrDecPkg;
  localparam int OP_W    = 3;
  localparam int MODE_W  = 3;
  localparam int SRC_W   = 2;
  localparam int INSTR_W = OP_W + MODE_W + SRC_W;
  localparam int MODE_N  = 1 << MODE_W;
  localparam int SRC_LSB  = 0;
  localparam int MODE_LSB = SRC_W;
  localparam int OP_LSB   = SRC_W + MODE_W;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 3'd0,
    OP_AND   = 3'd1,
    OP_OR    = 3'd2,
    OP_XOR   = 3'd3,
    OP_ADD   = 3'd4,
    OP_SUB   = 3'd5,
    OP_STORE = 3'd6,
    OP_JUMP  = 3'd7
  } opCode_e;

  typedef enum logic [SRC_W-1:0] {
    SRC_IMM = 2'd0,
    SRC_RAM = 2'd1,
    SRC_AC  = 2'd2,
    SRC_IN  = 2'd3
  } busSrc_e;

  typedef enum logic [1:0] {
    ADDR_D  = 2'd0,
    ADDR_X  = 2'd1,
    ADDR_YD = 2'd2,
    ADDR_YX = 2'd3
  } addrSel_e;

  typedef enum logic [MODE_W-1:0] {
    COND_FAR    = 3'd0,
    COND_GT     = 3'd1,
    COND_LT     = 3'd2,
    COND_NE     = 3'd3,
    COND_EQ     = 3'd4,
    COND_GE     = 3'd5,
    COND_LE     = 3'd6,
    COND_ALWAYS = 3'd7
  } cond_e;

  typedef struct packed {
    opCode_e  aluOp;
    busSrc_e  busSel;
    addrSel_e addrSel;
    logic     weAc;
    logic     weX;
    logic     weY;
    logic     weOut;
    logic     xInc;
    logic     ramWe;
    logic     isJump;
    cond_e    cond;
  } ctlStrobes_t;
endpackage

// File: rtl/decodeCtl.sv
module decodeCtl
  import instrDecPkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output ctlStrobes_t        strobes
);
  logic [OP_W-1:0]   opField;
  logic [MODE_W-1:0] modeField;
  logic [SRC_W-1:0]  srcField;
  logic [MODE_N-1:0] modeHot;
  logic isStore, isJump, isArith;

  assign opField   = instr[OP_LSB +: OP_W];
  assign modeField = instr[MODE_LSB +: MODE_W];
  assign srcField  = instr[SRC_LSB +: SRC_W];

  for (genvar m = 0; m < MODE_N; m++) begin : g_modeHot
    assign modeHot[m] = (modeField == MODE_W'(m));
  end

  assign isStore = (opField == OP_STORE);
  assign isJump  = (opField == OP_JUMP);
  assign isArith = !isStore && !isJump;

  always_comb begin
    strobes = '0;
    strobes.isJump = isJump;
    strobes.cond   = cond_e'(modeField);
    strobes.aluOp  = isArith ? opCode_e'(opField) : OP_LOAD;

    if (isStore && srcField == SRC_RAM) strobes.busSel = SRC_IMM;
    else                                strobes.busSel = busSrc_e'(srcField);

    if (isJump)                               strobes.addrSel = ADDR_D;
    else if (modeHot[1])                      strobes.addrSel = ADDR_X;
    else if (modeHot[2])                      strobes.addrSel = ADDR_YD;
    else if (modeHot[3] || modeHot[7])        strobes.addrSel = ADDR_YX;
    else                                      strobes.addrSel = ADDR_D;

    strobes.weAc  = isArith && (modeHot[0] || modeHot[1] || modeHot[2] || modeHot[3]);
    strobes.weX   = isArith && modeHot[4];
    strobes.weY   = isArith && modeHot[5];
    strobes.weOut = isArith && (modeHot[6] || modeHot[7]);
    strobes.xInc  = !isJump && modeHot[7];
    strobes.ramWe = isStore;
  end

  always_comb begin
    if (!$isunknown(instr)) begin
      // R5
      one_reg_write_chk: assert ($countones({strobes.weAc, strobes.weX, strobes.weY, strobes.weOut}) <= 1);
      // R6
      xinc_addr_chk: assert (!strobes.xInc || strobes.addrSel == ADDR_YX);
    end
  end
endmodule

// File: rtl/branchEval.sv
module branchEval
  import instrDecPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              isJump,
  input  cond_e             cond,
  input  logic [DATA_W-1:0] acc,
  output logic              pcLoadLow,
  output logic              pcLoadFar
);
  logic accNeg, accZero, taken;

  assign accNeg  = acc[DATA_W-1];
  assign accZero = (acc == '0);

  always_comb begin
    unique case (cond)
      COND_FAR:    taken = 1'b0;
      COND_GT:     taken = !accNeg && !accZero;
      COND_LT:     taken = accNeg;
      COND_NE:     taken = !accZero;
      COND_EQ:     taken = accZero;
      COND_GE:     taken = !accNeg;
      COND_LE:     taken = accNeg || accZero;
      COND_ALWAYS: taken = 1'b1;
      default:     taken = 1'b0;
    endcase
  end

  assign pcLoadFar = isJump && (cond == COND_FAR);
  assign pcLoadLow = isJump && taken;

  always_comb begin
    if (!$isunknown({isJump, cond, acc})) begin
      // R9
      always_taken_chk: assert (!(isJump && cond == COND_ALWAYS) || pcLoadLow);
      // R8
      eq_ne_split_chk: assert (!(isJump && (cond == COND_EQ || cond == COND_NE)) || (pcLoadLow == ((cond == COND_EQ) == (acc == '0))));
    end
  end
endmodule

// File: rtl/instrDecoder.sv
module instrDecoder
  import instrDecPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [7:0]        instr,
  input  logic [DATA_W-1:0] acc,
  output logic [2:0]        aluOp,
  output logic [1:0]        busSel,
  output logic [1:0]        addrSel,
  output logic              weAc,
  output logic              weX,
  output logic              weY,
  output logic              weOut,
  output logic              xInc,
  output logic              ramWe,
  output logic              pcLoadLow,
  output logic              pcLoadFar
);
  ctlStrobes_t strobes;

  decodeCtl u_ctl (
    .instr   (instr),
    .strobes (strobes)
  );

  branchEval #(.DATA_W(DATA_W)) u_branch (
    .isJump    (strobes.isJump),
    .cond      (strobes.cond),
    .acc       (acc),
    .pcLoadLow (pcLoadLow),
    .pcLoadFar (pcLoadFar)
  );

  assign aluOp   = strobes.aluOp;
  assign busSel  = strobes.busSel;
  assign addrSel = strobes.addrSel;
  assign weAc    = strobes.weAc;
  assign weX     = strobes.weX;
  assign weY     = strobes.weY;
  assign weOut   = strobes.weOut;
  assign xInc    = strobes.xInc;
  assign ramWe   = strobes.ramWe;

  always_comb begin
    if (!$isunknown({instr, acc})) begin
      // R7
      one_pc_load_chk: assert (!(pcLoadLow && pcLoadFar));
      // R2
      store_no_reg_chk: assert (!ramWe || !(weAc || weX || weY || weOut));
      // R10
      jump_quiet_chk: assert (!(pcLoadLow || pcLoadFar) || !(ramWe || xInc || weAc || weX || weY || weOut));
      // R2
      store_bus_chk: assert (!ramWe || busSel != SRC_RAM);
    end
  end
endmodule

// File: tb/sim_instrDecoder.sv
module sim_instrDecoder;
  typedef struct {
    logic [7:0] instr;
    logic [7:0] acc;
    logic [2:0] aluOp;
    logic [1:0] busSel;
    logic [1:0] addrSel;
    logic weAc, weX, weY, weOut, xInc, ramWe, pcLow, pcFar;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] instr = 8'h00;
  logic [7:0] acc = 8'h00;
  logic [2:0] aluOp;
  logic [1:0] busSel, addrSel;
  logic weAc, weX, weY, weOut, xInc, ramWe, pcLoadLow, pcLoadFar;

  exp_t q[$];
  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  instrDecoder #(.DATA_W(8)) u0 (
    .instr(instr), .acc(acc), .aluOp(aluOp), .busSel(busSel), .addrSel(addrSel),
    .weAc(weAc), .weX(weX), .weY(weY), .weOut(weOut), .xInc(xInc), .ramWe(ramWe),
    .pcLoadLow(pcLoadLow), .pcLoadFar(pcLoadFar)
  );

  function automatic exp_t model(input logic [7:0] i, input logic [7:0] a);
    exp_t e;
    int op, md, sr;
    bit neg, zer, tk;
    op = int'(i[7:5]); md = int'(i[4:2]); sr = int'(i[1:0]);
    neg = a[7]; zer = (a == 8'h00);
    e.instr = i; e.acc = a;
    e.aluOp = (op <= 5) ? 3'(op) : 3'd0;
    e.busSel = (op == 6 && sr == 1) ? 2'd0 : 2'(sr);
    e.weAc = 0; e.weX = 0; e.weY = 0; e.weOut = 0;
    e.xInc = 0; e.ramWe = 0; e.pcLow = 0; e.pcFar = 0;
    if (op == 7) e.addrSel = 2'd0;
    else case (md)
      1: e.addrSel = 2'd1;
      2: e.addrSel = 2'd2;
      3, 7: e.addrSel = 2'd3;
      default: e.addrSel = 2'd0;
    endcase
    if (op <= 5) begin
      if (md <= 3) e.weAc = 1;
      else if (md == 4) e.weX = 1;
      else if (md == 5) e.weY = 1;
      else e.weOut = 1;
    end
    if (op != 7 && md == 7) e.xInc = 1;
    if (op == 6) e.ramWe = 1;
    if (op == 7) begin
      case (md)
        0: tk = 0;
        1: tk = !neg && !zer;
        2: tk = neg;
        3: tk = !zer;
        4: tk = zer;
        5: tk = !neg;
        6: tk = neg || zer;
        default: tk = 1;
      endcase
      e.pcFar = (md == 0);
      e.pcLow = tk;
    end
    return e;
  endfunction

  task automatic drive(input logic [7:0] i, input logic [7:0] a);
    @(negedge clk);
    instr = i;
    acc = a;
    q.push_back(model(i, a));
  endtask

  task automatic cmp(input string tag, input logic [3:0] act, input logic [3:0] exp, input exp_t e);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s instr=%02h acc=%02h actual=%0h expected=%0h", tag, e.instr, e.acc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      vectors++;
      cmp("R1/R2 busSel", {2'b0, busSel}, {2'b0, e.busSel}, e);
      cmp("R3 aluOp", {1'b0, aluOp}, {1'b0, e.aluOp}, e);
      cmp("R4 addrSel", {2'b0, addrSel}, {2'b0, e.addrSel}, e);
      cmp("R5 writes", {weAc, weX, weY, weOut}, {e.weAc, e.weX, e.weY, e.weOut}, e);
      cmp("R6 xInc", {3'b0, xInc}, {3'b0, e.xInc}, e);
      cmp("R2 ramWe", {3'b0, ramWe}, {3'b0, e.ramWe}, e);
      cmp("R7 pcLoadFar", {3'b0, pcLoadFar}, {3'b0, e.pcFar}, e);
      cmp("R8/R9 pcLoadLow", {3'b0, pcLoadLow}, {3'b0, e.pcLow}, e);
      // R10 is covered by the write, ramWe and PC load comparisons above
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected=0 pending", q.size());
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] accSet [6];
    accSet[0] = 8'h00; accSet[1] = 8'h01; accSet[2] = 8'h7F;
    accSet[3] = 8'h80; accSet[4] = 8'hFF; accSet[5] = 8'h42;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // Reset-state vector: all-zero byte is load immediate into the accumulator
    drive(8'h00, 8'h00);
    // Full sweep of the encoding space against signed boundary values (R1..R10)
    for (int a = 0; a < 6; a++) begin
      for (int i = 0; i < 256; i++) drive(8'(i), accSet[a]);
    end
    // Mode-7 overlaps: arithmetic to output with X++, and store with X++
    drive(8'b100_111_01, 8'h05);
    drive(8'b110_111_01, 8'h05);
    // Far jump with each accumulator extreme (R7)
    drive(8'b111_000_10, 8'h80);
    drive(8'b111_000_00, 8'h00);
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule